// File: doc/BRIEF.md
# Ultra DMA Read-Burst Start Sequencer

This block sits on the host side of a parallel ATA-style bus and opens an Ultra DMA data-in burst. The surrounding controller issues a one-cycle start pulse with a 3-bit timing mode. The sequencer then waits, for as long as it takes, until the device raises its DMA request. It marks the address and chip-select lines as frozen, asserts the active-low acknowledge after the address setup window, and keeps STOP high and host-ready negated for the envelope window. It then drops STOP and asserts host-ready together. After that it watches the device strobe line for its first transition.

When a strobe edge arrives in time, the sequencer raises a burst-active level and pulses `done_o`, and a data-capture path takes over. When no edge arrives in time, it releases the acknowledge, pulses `err_o` and returns to idle. If the device withdraws its request before acknowledge is given, the sequencer quietly returns to idle. The request and strobe inputs pass through two flip-flop stages before use. All nanosecond limits are turned into clock counts at elaboration time from a clock-period parameter: minimums are rounded up and maximums rounded down.

Top module: `udma_rd_init`

## Requirements
- R1: After reset `dmack_n_o`, `stop_o` and `hdmardy_n_o` are 1, and `addr_hold_o`, `burst_o`, `busy_o`, `done_o` and `err_o` are 0.
- R2: After a start pulse, the block waits without limit while `dmarq_i` is low. During that wait `busy_o` is 1, `dmack_n_o` stays 1 and `addr_hold_o` stays 0.
- R3: Once the synchronized request is seen, `addr_hold_o` rises. `dmack_n_o` falls exactly ceil(20 ns / clock period) cycles later, which is 3 cycles at 8 ns.
- R4: `stop_o` falls and `hdmardy_n_o` falls in the same cycle, exactly ceil(20 ns / clock period) cycles after `dmack_n_o` falls. This is 3 cycles at 8 ns, which lies inside both the 20–70 ns window and the tighter 20–50 ns window of the fastest mode.
- R5: A transition of either polarity on `dstrobe_i` while the block waits for the first strobe raises `burst_o` and gives exactly one `done_o` pulse. Acknowledge stays asserted and STOP stays low.
- R6: If the synchronized strobe shows no edge, `err_o` is pulsed exactly F cycles after `stop_o` falls, and `dmack_n_o`, `stop_o` and `hdmardy_n_o` return to 1 in that same cycle. F is floor(limit / clock period), with limits of 230, 200, 170, 130, 120 and 90 ns for modes 0 to 5, giving 28, 25, 21, 16, 15 and 11 cycles at 8 ns. A strobe change driven k cycles after `stop_o` falls is accepted if k ≤ F−3 and times out if k = F−2.
- R7: The mode is captured at the start pulse, and later changes of `mode_i` have no effect on that burst. Mode codes 6 and 7 use the mode 5 limits.
- R8: If the request drops before acknowledge is asserted, the block returns to idle. `dmack_n_o` never falls, no `done_o` or `err_o` pulse is given, and `busy_o` and `addr_hold_o` return to 0.
- R9: After acknowledge is released, either by `burst_end_i` during a burst or by a timeout, `addr_hold_o` stays 1 for exactly ceil(20 ns / clock period) cycles and then falls together with `busy_o`.
- R10: `start_i` is ignored while `busy_o` is 1. A start pulse during an active burst changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to open a read burst |
| mode_i | input | 3 | Timing mode 0–5 (6, 7 act as 5), captured at start |
| burst_end_i | input | 1 | From the capture/termination logic: leave the burst |
| dmarq_i | input | 1 | Device DMA request (asynchronous) |
| dstrobe_i | input | 1 | Device data strobe (asynchronous) |
| dmack_n_o | output | 1 | Host DMA acknowledge, active low |
| stop_o | output | 1 | Host STOP line |
| hdmardy_n_o | output | 1 | Host ready for data, active low |
| addr_hold_o | output | 1 | Address and chip-select lines must stay frozen |
| burst_o | output | 1 | First strobe seen; capture path owns the bus |
| busy_o | output | 1 | Sequencer is not idle |
| done_o | output | 1 | One-cycle pulse on a successful burst start |
| err_o | output | 1 | One-cycle pulse on first-strobe timeout |

## Verification
The hardest case to reach is the edge of the first-strobe window. The strobe passes through two synchronizer stages and an edge register before the sequencer sees it, so the last accepted port transition sits three cycles before the limit. The bench counts clock cycles from the falling edge of `stop_o` in the fastest mode. It toggles the strobe once on the last accepted cycle and once a cycle after it, and expects a clean start in the first case and a timeout in the second. A second hard case is a request that drops inside the address setup window. The bench lowers `dmarq_i` in the same cycle that `addr_hold_o` is first seen, so the drop reaches the sequencer on the last setup cycle, just before acknowledge would be given.

// File: rtl/udma_rd_pkg.sv
package udma_rd_pkg;

    localparam int ADDR_SETUP_PS = 20000;
    localparam int ENV_MIN_PS    = 20000;
    localparam int ENV_MAX_PS    = 70000;
    localparam int ENV_MAX5_PS   = 50000;
    localparam int FS_SLOWEST_PS = 230000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_ADDR_SETUP,
        ST_ACK_ON,
        ST_ENVELOPE,
        ST_WAIT_STROBE,
        ST_BURST,
        ST_ERROR,
        ST_HOLD
    } seq_state_e;

    function automatic int cyc_ceil(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int cyc_floor(input int ps, input int clk_ps);
        return ps / clk_ps;
    endfunction

    // first-strobe limit in picoseconds per mode
    function automatic int first_strobe_ps(input logic [2:0] m);
        case (m)
            3'd0:    return 230000;
            3'd1:    return 200000;
            3'd2:    return 170000;
            3'd3:    return 130000;
            3'd4:    return 120000;
            default: return 90000;
        endcase
    endfunction

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/udma_edge.sv
module udma_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);
    logic last_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= level_i;
    end
    assign edge_o = level_i ^ last_q;
endmodule

// File: rtl/udma_mode_timing.sv
module udma_mode_timing #(
    parameter int CLK_PS = 8000,
    parameter int CNT_W  = 5
) (
    input  logic [2:0]       mode_i,
    output logic [CNT_W-1:0] fs_cyc_o
);
    localparam int NMODES = 6;

    logic [CNT_W-1:0] tab [NMODES];

    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        localparam int FS_C =
            udma_rd_pkg::cyc_floor(udma_rd_pkg::first_strobe_ps(3'(m)), CLK_PS);
        assign tab[m] = CNT_W'(FS_C);
    end

    // codes above the fastest mode fall back to it
    always_comb begin
        fs_cyc_o = tab[NMODES-1];
        for (int m = 0; m < NMODES; m++) begin
            if (mode_i == 3'(m)) fs_cyc_o = tab[m];
        end
    end
endmodule

// File: rtl/udma_rd_init.sv
module udma_rd_init #(
    parameter int CLK_PS = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] mode_i,
    input  logic       burst_end_i,
    input  logic       dmarq_i,
    input  logic       dstrobe_i,
    output logic       dmack_n_o,
    output logic       stop_o,
    output logic       hdmardy_n_o,
    output logic       addr_hold_o,
    output logic       burst_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    import udma_rd_pkg::*;

    localparam int ACK_CYC    = cyc_ceil(ADDR_SETUP_PS, CLK_PS);
    localparam int ENV_CYC    = cyc_ceil(ENV_MIN_PS, CLK_PS);
    localparam int FS_MAX_CYC = cyc_floor(FS_SLOWEST_PS, CLK_PS);
    localparam int CNT_MAX    = (FS_MAX_CYC > ACK_CYC) ? FS_MAX_CYC : ACK_CYC;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] fs_lim;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic [1:0]       sync_w;
    logic             req_s;
    logic             strobe_s;
    logic             strobe_edge;
    logic [CNT_W-1:0] fs_cyc;

    udma_sync #(.W(2), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dstrobe_i, dmarq_i}),
        .sync_o  (sync_w)
    );
    assign req_s    = sync_w[0];
    assign strobe_s = sync_w[1];

    udma_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (strobe_s),
        .edge_o  (strobe_edge)
    );

    udma_mode_timing #(.CLK_PS(CLK_PS), .CNT_W(CNT_W)) timing_i (
        .mode_i   (mode_i),
        .fs_cyc_o (fs_cyc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_WAIT_REQ;
                    d.fs_lim = fs_cyc;
                end
            end
            ST_WAIT_REQ: begin
                if (req_s) begin
                    d.st  = ST_ADDR_SETUP;
                    d.cnt = CNT_W'(ACK_CYC - 1);
                end
            end
            ST_ADDR_SETUP: begin
                if (!req_s)           d.st  = ST_IDLE;
                else if (q.cnt == '0) d.st  = ST_ACK_ON;
                else                  d.cnt = q.cnt - 1'b1;
            end
            ST_ACK_ON: begin
                d.st  = ST_ENVELOPE;
                d.cnt = CNT_W'(ENV_CYC - 2);
            end
            ST_ENVELOPE: begin
                if (q.cnt == '0) begin
                    d.st  = ST_WAIT_STROBE;
                    d.cnt = q.fs_lim - 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WAIT_STROBE: begin
                if (strobe_edge) begin
                    d.st   = ST_BURST;
                    d.done = 1'b1;
                end else if (q.cnt == '0) begin
                    d.st  = ST_ERROR;
                    d.err = 1'b1;
                    d.cnt = CNT_W'(ACK_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_BURST: begin
                if (burst_end_i) begin
                    d.st  = ST_HOLD;
                    d.cnt = CNT_W'(ACK_CYC - 1);
                end
            end
            ST_ERROR, ST_HOLD: begin
                if (q.cnt == '0) d.st  = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.cnt    <= '0;
            q.fs_lim <= '0;
            q.done   <= 1'b0;
            q.err    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    logic ack_on, host_go;
    assign ack_on  = (q.st == ST_ACK_ON) || (q.st == ST_ENVELOPE) ||
                     (q.st == ST_WAIT_STROBE) || (q.st == ST_BURST);
    assign host_go = (q.st == ST_WAIT_STROBE) || (q.st == ST_BURST);

    assign dmack_n_o   = !ack_on;
    assign stop_o      = !host_go;
    assign hdmardy_n_o = !host_go;
    assign addr_hold_o = (q.st != ST_IDLE) && (q.st != ST_WAIT_REQ);
    assign burst_o     = (q.st == ST_BURST);
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign err_o       = q.err;

    initial begin
        a_r4_env_fits: assert (ENV_CYC >= 2 && ENV_CYC <= cyc_floor(ENV_MAX5_PS, CLK_PS)
                               && ENV_CYC <= cyc_floor(ENV_MAX_PS, CLK_PS));
    end

    a_r3_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n_o) |-> $past(addr_hold_o));

    a_r4_stop_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_o) |-> (!dmack_n_o && !hdmardy_n_o && $past(!dmack_n_o)));

    a_r5_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !hdmardy_n_o |-> !dmack_n_o);

    a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR_SETUP && !req_s) |=> (q.st == ST_IDLE && dmack_n_o));

    a_r9_hold_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> addr_hold_o);

endmodule

// File: tb/udma_rd_init_tb_top.sv
`timescale 1ns/1ps
module udma_rd_init_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic burst_end_i = 1'b0;
    logic dmarq_i = 1'b0;
    logic dstrobe_i = 1'b0;
    logic dmack_n_o, stop_o, hdmardy_n_o, addr_hold_o, burst_o, busy_o, done_o, err_o;

    int tests = 0;
    int fails = 0;

    localparam int CLK_PS = 8000;
    localparam int EXP_ACK = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_ENV = (20000 + CLK_PS - 1) / CLK_PS;

    always #4 clk = ~clk;

    udma_rd_init #(.CLK_PS(CLK_PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .burst_end_i(burst_end_i), .dmarq_i(dmarq_i), .dstrobe_i(dstrobe_i),
        .dmack_n_o(dmack_n_o), .stop_o(stop_o), .hdmardy_n_o(hdmardy_n_o),
        .addr_hold_o(addr_hold_o), .burst_o(burst_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic int exp_fs(input int m);
        int ns;
        case (m)
            0: ns = 230; 1: ns = 200; 2: ns = 170;
            3: ns = 130; 4: ns = 120; default: ns = 90;
        endcase
        return (ns * 1000) / CLK_PS;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 0; burst_end_i = 0; dmarq_i = 0; dstrobe_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [2:0] m);
        mode_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // raises the request and measures up to the STOP fall; returns on that negedge
    task automatic open_to_stop(input string tag, output int ok);
        int n = 0, nh = -1, nd = -1, ns = -1;
        dmarq_i = 1'b1;
        while (n < 60 && ns < 0) begin
            @(negedge clk); n++;
            if (addr_hold_o && nh < 0) nh = n;
            if (!dmack_n_o && nd < 0) nd = n;
            if (!stop_o && ns < 0) ns = n;
        end
        ok = (ns > 0);
        chk({tag, " R3 setup cycles"}, nd - nh, EXP_ACK);
        chk({tag, " R4 envelope cycles"}, ns - nd, EXP_ENV);
        chk({tag, " R4 ready with stop"}, hdmardy_n_o, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 idle lines", {dmack_n_o, stop_o, hdmardy_n_o}, 3'b111);
        chk("R1 idle status", {addr_hold_o, burst_o, busy_o, done_o, err_o}, 5'b0);
    endtask

    task automatic t_no_request();
        int bad = 0;
        do_reset();
        pulse_start(3'd2);
        repeat (60) begin
            @(negedge clk);
            if (!dmack_n_o || addr_hold_o || !busy_o) bad++;
        end
        chk("R2 waits for request", bad, 0);
    endtask

    task automatic t_normal(input logic [2:0] m, input logic pol);
        int ok, dones = 0, nr = -1, na = -1, n = 0, bad = 0;
        do_reset();
        dstrobe_i = pol;
        repeat (4) @(negedge clk);
        pulse_start(m);
        open_to_stop("normal", ok);
        dstrobe_i = ~pol;
        repeat (8) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        chk("R5 burst active", burst_o, 1);
        chk("R5 single done pulse", dones, 1);
        chk("R5 ack held low", {dmack_n_o, stop_o}, 2'b00);
        pulse_start(3'd0);
        repeat (4) begin
            @(negedge clk);
            if (!burst_o || dmack_n_o || stop_o || done_o || err_o) bad++;
        end
        chk("R10 start ignored while busy", bad, 0);
        burst_end_i = 1'b1;
        while (n < 20 && na < 0) begin
            @(negedge clk); n++;
            burst_end_i = 1'b0;
            if (dmack_n_o && nr < 0) nr = n;
            if (!addr_hold_o && na < 0) na = n;
        end
        chk("R9 hold after burst end", na - nr, EXP_ACK);
        chk("R9 idle after hold", busy_o, 0);
    endtask

    task automatic t_timeout(input logic [2:0] m, input logic [2:0] later, input int fs_mode);
        int ok, n = 0, ne = -1, nr = -1, na = -1;
        do_reset();
        pulse_start(m);
        mode_i = later;
        open_to_stop("timeout", ok);
        while (n < 60 && ne < 0) begin
            @(negedge clk); n++;
            if (err_o) ne = n;
        end
        chk($sformatf("R6 timeout mode %0d", fs_mode), ne, exp_fs(fs_mode));
        chk("R6 lines released", {dmack_n_o, stop_o, hdmardy_n_o}, 3'b111);
        nr = 0;
        n = 0;
        while (n < 20 && na < 0) begin
            @(negedge clk); n++;
            if (!addr_hold_o) na = n;
        end
        chk("R9 hold after timeout", na, EXP_ACK);
        chk("R9 busy cleared", busy_o, 0);
    endtask

    task automatic t_boundary(input int k, input int expect_ok);
        int ok, dones = 0, errs = 0;
        do_reset();
        pulse_start(3'd5);
        open_to_stop("edge", ok);
        repeat (k) @(negedge clk);
        dstrobe_i = ~dstrobe_i;
        repeat (12) begin
            @(negedge clk);
            if (done_o) dones++;
            if (err_o) errs++;
        end
        chk($sformatf("R6 strobe at k=%0d done", k), dones, expect_ok);
        chk($sformatf("R6 strobe at k=%0d err", k), errs, 1 - expect_ok);
    endtask

    task automatic t_abort();
        int bad = 0, n = 0;
        do_reset();
        pulse_start(3'd1);
        dmarq_i = 1'b1;
        while (n < 20 && !addr_hold_o) begin
            @(negedge clk); n++;
        end
        dmarq_i = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (!dmack_n_o || done_o || err_o) bad++;
        end
        chk("R8 no ack after drop", bad, 0);
        chk("R8 back to idle", {busy_o, addr_hold_o}, 2'b00);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_no_request();
        t_normal(3'd0, 1'b0);
        t_normal(3'd5, 1'b1);
        t_timeout(3'd0, 3'd0, 0);
        t_timeout(3'd3, 3'd3, 3);
        t_timeout(3'd7, 3'd0, 5);   // R7: code 7 acts as 5, later change ignored
        t_timeout(3'd1, 3'd5, 1);   // R7: captured mode wins
        t_boundary(exp_fs(5) - 3, 1);
        t_boundary(exp_fs(5) - 2, 0);
        t_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule